// File: doc/BRIEF.md
# Character I/O Flags and Interrupt Sequencer

This block sits beside an accumulator-based core and owns everything that the core's single-character input and output path needs. It holds one received character with a "character waiting" flag and one outgoing character with a "printer free" flag. It also holds the interrupt-enable flip-flop and the interrupt-cycle flip-flop. When the core reaches the execute step of an I/O-class instruction, it raises `io_exec` and presents instruction bits 11..6 on `io_sel`. The block then performs the selected operation in that cycle. An operation can load AC bits 7..0, latch a character for output, request a program-counter skip, or change the interrupt enable.

The block watches the core's sequence-counter phase. On any clock edge where the phase is none of the first three steps, interrupts are enabled and either flag is up, the interrupt-cycle flip-flop sets. While that flip-flop is set, `irq_cycle` tells the core to abandon its normal fetch. The block then runs three steps:
- In the first step it snapshots the program counter.
- In the second step it writes the snapshot to memory word 0 and clears the program counter.
- In the third step it bumps the program counter to 1, disables interrupts, drops the interrupt-cycle flip-flop and asks the core to reset its sequence counter.

Both character ports are valid/ready streams. The input side raises `in_ready` only while no character is waiting. A transfer takes place on a clock edge where `in_valid` and `in_ready` are both high. The output side raises `out_valid` while a character awaits the device. `out_data` holds steady until the device takes it with `out_ready`. A device may hold `in_valid` or `out_ready` high indefinitely, and nothing is lost.

Top module: `chario_irq_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `irq_cycle` is 0. Interrupts are disabled, so a following edge with `sc_phase` = 000 does not set `irq_cycle`.
- R2: An input transfer (`in_valid` & `in_ready` at an edge) stores `in_data` and raises the waiting flag, so `in_ready` reads 0 from the next cycle. The INP operation is `io_sel` bit 5 with `io_exec`. In the same cycle, INP drives `acc_lo_load` = 1 and presents the stored character on `acc_lo_out`, and it clears the waiting flag at the edge. If a transfer and INP fall on the same edge, the waiting flag ends up set.
- R3: The OUT operation is `io_sel` bit 4 with `io_exec`. At the edge it latches `acc_lo_in` and clears the free flag, so from the next cycle `out_valid` = 1 and `out_data` is the latched value. Both hold steady until an edge with `out_ready` = 1, after which `out_valid` is 0. If OUT and a device accept fall on the same edge, OUT wins: `out_valid` stays 1 and `out_data` carries the new character.
- R4: The SKI operation (`io_sel` bit 3) drives `pc_inc` high in the same cycle exactly when the waiting flag is 1. The SKO operation (`io_sel` bit 2) does the same exactly when the free flag is 1.
- R5: ION (`io_sel` bit 1) enables interrupts at the edge, and IOF (`io_sel` bit 0) disables them. If both are selected together, IOF wins.
- R6: `irq_cycle` sets at an edge only when all of these hold: `sc_phase` is 000, interrupts are enabled, and at least one flag is 1. A phase of T0, T1 or T2 (one-hot bit 0, 1 or 2 of `sc_phase`) blocks the set.
- R7: While `irq_cycle` is 1, the phase steps run as follows:
  - At T0 the block captures `pc_in`.
  - At T1 it drives `mem_we` = 1, `mem_addr` = 0, `mem_wdata` = the captured value zero-extended, and `pc_clear` = 1.
  - At T2 it drives `pc_inc` = 1 and `sc_clear` = 1.
  - After the T2 edge, `irq_cycle` is 0 and interrupts are disabled.
- R8: With `io_exec` = 0, no value of `io_sel` has any effect: no `pc_inc`, no `acc_lo_load`, and no change to either flag or to the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Device offers a character |
| in_ready | output | 1 | No character waiting; a transfer is accepted |
| in_data | input | 8 | Offered character |
| out_valid | output | 1 | A character awaits the device |
| out_ready | input | 1 | Device takes the character |
| out_data | output | 8 | Outgoing character |
| io_exec | input | 1 | Execute step of an I/O-class instruction |
| io_sel | input | 6 | Instruction bits 11..6 selecting the operation |
| acc_lo_in | input | 8 | AC bits 7..0 from the core |
| acc_lo_out | output | 8 | Character to load into AC bits 7..0 |
| acc_lo_load | output | 1 | Load AC bits 7..0 this cycle |
| pc_in | input | 12 | Current program counter |
| pc_inc | output | 1 | Increment program counter (skip or interrupt step) |
| pc_clear | output | 1 | Clear program counter |
| sc_phase | input | 3 | One-hot T0/T1/T2 phase of the sequence counter; 000 otherwise |
| sc_clear | output | 1 | Reset the sequence counter |
| irq_cycle | output | 1 | Interrupt cycle active; normal fetch suppressed |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 16 | Memory write data |

## Verification
Two collisions are provoked on purpose. In the first, the core executes OUT on the same edge where the device accepts the previous character. The bench then expects `out_valid` still high and `out_data` equal to the second character. In the second, a device delivery lands on the edge of an INP. The bench expects the waiting flag to survive, which it reads as `in_ready` low afterwards. Around these cases, every character value is swept through both ports, and every `io_sel` pattern is applied with `io_exec` low. Each blocked phase is tried for the interrupt set.

// File: rtl/chario_pkg.sv
package chario_pkg;
  localparam int SEL_W   = 6;
  localparam int SEL_INP = 5;
  localparam int SEL_OUT = 4;
  localparam int SEL_SKI = 3;
  localparam int SEL_SKO = 2;
  localparam int SEL_ION = 1;
  localparam int SEL_IOF = 0;

  typedef struct packed {
    logic inp;
    logic outc;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_cmd_t;
endpackage

// File: rtl/chario_decode.sv
module chario_decode
  import chario_pkg::*;
(
  input  logic             io_exec,
  input  logic [SEL_W-1:0] io_sel,
  output io_cmd_t          cmd
);
  logic [SEL_W-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < SEL_W; g++) begin : g_gate
      assign gated[g] = io_exec & io_sel[g];
    end
  endgenerate

  always_comb begin
    cmd.inp  = gated[SEL_INP];
    cmd.outc = gated[SEL_OUT];
    cmd.ski  = gated[SEL_SKI];
    cmd.sko  = gated[SEL_SKO];
    cmd.ion  = gated[SEL_ION];
    cmd.iof  = gated[SEL_IOF];
  end
endmodule

// File: rtl/chario_ports.sv
module chario_ports #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  input  logic              inp_do,
  input  logic              out_do,
  input  logic [CHAR_W-1:0] acc_in,
  output logic [CHAR_W-1:0] rx_char,
  output logic              fgi,
  output logic              fgo
);
  logic              fgi_q, fgo_q;
  logic [CHAR_W-1:0] rx_q, tx_q;
  logic              take_in, take_out;

  assign take_in  = in_valid & ~fgi_q;
  assign take_out = out_ready & ~fgo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fgi_q <= 1'b0;
      fgo_q <= 1'b1;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      if (take_in) begin
        rx_q  <= in_data;
        fgi_q <= 1'b1;
      end else if (inp_do) begin
        fgi_q <= 1'b0;
      end
      if (out_do) begin
        tx_q  <= acc_in;
        fgo_q <= 1'b0;
      end else if (take_out) begin
        fgo_q <= 1'b1;
      end
    end
  end

  assign in_ready  = ~fgi_q;
  assign out_valid = ~fgo_q;
  assign out_data  = tx_q;
  assign rx_char   = rx_q;
  assign fgi       = fgi_q;
  assign fgo       = fgo_q;

  assert_in_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (fgi_q && rx_q == $past(in_data)));

  assert_flag_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fgi_q && !inp_do) |=> fgi_q);

  assert_out_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !out_do) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/chario_irq.sv
module chario_irq #(
  parameter int ADDR_W    = 12,
  parameter int WORD_W    = 16,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sc_phase,
  input  logic              ion,
  input  logic              iof,
  input  logic              fgi,
  input  logic              fgo,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              irq_cycle,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_clear,
  output logic              pc_bump,
  output logic              sc_clear
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic              ien_q, r_q;
  logic [ADDR_W-1:0] tr_q;
  logic              outside, want, step0, step1, step2;

  assign outside = (sc_phase == 3'b000);
  assign want    = outside & ien_q & (fgi | fgo);
  assign step0   = r_q & sc_phase[0];
  assign step1   = r_q & sc_phase[1];
  assign step2   = r_q & sc_phase[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      r_q   <= 1'b0;
      tr_q  <= '0;
    end else begin
      if (step2 || iof)  ien_q <= 1'b0;
      else if (ion)      ien_q <= 1'b1;
      if (step2)         r_q <= 1'b0;
      else if (want)     r_q <= 1'b1;
      if (step0)         tr_q <= pc_in;
    end
  end

  assign irq_cycle = r_q;
  assign mem_we    = step1;
  assign mem_addr  = ADDR_W'(SAVE_ADDR);
  assign mem_wdata = {{PAD_W{1'b0}}, tr_q};
  assign pc_clear  = step1;
  assign pc_bump   = step2;
  assign sc_clear  = step2;

  assert_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q) |-> $past(sc_phase == 3'b000 && ien_q && (fgi || fgo)));

  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q && sc_phase[2]) |=> (!r_q && !ien_q));

  assert_saved_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q && sc_phase[1] && $past(r_q && sc_phase[0]))
      |-> (mem_wdata[ADDR_W-1:0] == $past(pc_in)));
endmodule

// File: rtl/chario_irq_ctrl.sv
module chario_irq_ctrl
  import chario_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int WORD_W    = 16,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  input  logic              io_exec,
  input  logic [SEL_W-1:0]  io_sel,
  input  logic [CHAR_W-1:0] acc_lo_in,
  output logic [CHAR_W-1:0] acc_lo_out,
  output logic              acc_lo_load,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              pc_inc,
  output logic              pc_clear,
  input  logic [2:0]        sc_phase,
  output logic              sc_clear,
  output logic              irq_cycle,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  io_cmd_t cmd;
  logic    fgi, fgo, pc_bump;

  chario_decode u_decode (
    .io_exec (io_exec),
    .io_sel  (io_sel),
    .cmd     (cmd)
  );

  chario_ports #(.CHAR_W(CHAR_W)) u_ports (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .inp_do    (cmd.inp),
    .out_do    (cmd.outc),
    .acc_in    (acc_lo_in),
    .rx_char   (acc_lo_out),
    .fgi       (fgi),
    .fgo       (fgo)
  );

  chario_irq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SAVE_ADDR(SAVE_ADDR)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sc_phase  (sc_phase),
    .ion       (cmd.ion),
    .iof       (cmd.iof),
    .fgi       (fgi),
    .fgo       (fgo),
    .pc_in     (pc_in),
    .irq_cycle (irq_cycle),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_clear  (pc_clear),
    .pc_bump   (pc_bump),
    .sc_clear  (sc_clear)
  );

  assign acc_lo_load = cmd.inp;
  assign pc_inc      = pc_bump | (cmd.ski & fgi) | (cmd.sko & fgo);

  assert_skip_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_sel[SEL_SKI] && !in_ready && !irq_cycle) |-> pc_inc);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_exec && !irq_cycle) |-> (!pc_inc && !acc_lo_load));
endmodule

// File: tb/chario_irq_ctrl_tb.sv
module chario_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0, io_exec = 1'b0;
  logic [7:0]  in_data = '0, acc_lo_in = '0;
  logic [5:0]  io_sel = '0;
  logic [11:0] pc_in = '0;
  logic [2:0]  sc_phase = '0;
  logic        in_ready, out_valid, acc_lo_load, pc_inc, pc_clear, sc_clear, irq_cycle, mem_we;
  logic [7:0]  out_data, acc_lo_out;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  chario_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .io_exec(io_exec), .io_sel(io_sel), .acc_lo_in(acc_lo_in), .acc_lo_out(acc_lo_out),
    .acc_lo_load(acc_lo_load), .pc_in(pc_in), .pc_inc(pc_inc), .pc_clear(pc_clear),
    .sc_phase(sc_phase), .sc_clear(sc_clear), .irq_cycle(irq_cycle), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic exec(input logic [5:0] sel);
    io_exec = 1'b1;
    io_sel  = sel;
  endtask

  task automatic idle();
    io_exec = 1'b0;
    io_sel  = '0;
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    settle();
    // R1 reset state
    eq("R1 in_ready", in_ready, 1);
    eq("R1 out_valid", out_valid, 0);
    eq("R1 irq_cycle", irq_cycle, 0);
    tick();
    settle();
    eq("R1 ien off", irq_cycle, 0);

    // R2 every character through the input port
    for (int c = 0; c < 256; c++) begin
      in_valid = 1'b1; in_data = 8'(c);
      settle();
      eq("R2 ready before", in_ready, 1);
      tick();
      in_valid = 1'b0;
      settle();
      eq("R2 waiting", in_ready, 0);
      exec(6'b100000);
      settle();
      eq("R2 load", acc_lo_load, 1);
      eq("R2 char", acc_lo_out, c);
      tick();
      idle();
      settle();
      eq("R2 cleared", in_ready, 1);
    end

    // R3 every character through the output port
    for (int v = 0; v < 256; v++) begin
      acc_lo_in = 8'(v ^ 8'h5A);
      exec(6'b010000);
      tick();
      idle();
      settle();
      eq("R3 valid", out_valid, 1);
      eq("R3 data", out_data, v ^ 8'h5A);
      acc_lo_in = 8'hFF & ~8'(v);
      tick();
      settle();
      eq("R3 hold", out_data, v ^ 8'h5A);
      out_ready = 1'b1;
      tick();
      out_ready = 1'b0;
      settle();
      eq("R3 taken", out_valid, 0);
    end

    // R3 collision: OUT and accept on one edge
    acc_lo_in = 8'h11; exec(6'b010000); tick(); idle();
    acc_lo_in = 8'h22; exec(6'b010000); out_ready = 1'b1; tick(); idle();
    settle();
    eq("R3 collide valid", out_valid, 1);
    eq("R3 collide data", out_data, 8'h22);
    out_ready = 1'b1; tick(); idle(); settle();

    // R2 collision: delivery on INP edge (flag clear beforehand)
    in_valid = 1'b1; in_data = 8'h3C; exec(6'b100000); tick(); idle(); settle();
    eq("R2 collide flag", in_ready, 0);
    exec(6'b100000); settle();
    eq("R2 collide char", acc_lo_out, 8'h3C);
    tick(); idle(); settle();

    // R4 skips with both flag states (fgi=0, fgo=1 now)
    exec(6'b001000); settle(); eq("R4 SKI low", pc_inc, 0);
    exec(6'b000100); settle(); eq("R4 SKO high", pc_inc, 1);
    idle();
    acc_lo_in = 8'h01; exec(6'b010000); tick(); idle();
    in_valid = 1'b1; in_data = 8'h77; tick(); idle();
    exec(6'b001000); settle(); eq("R4 SKI high", pc_inc, 1);
    exec(6'b000100); settle(); eq("R4 SKO low", pc_inc, 0);
    idle();
    out_ready = 1'b1; tick(); idle();   // fgi=1, fgo=1

    // R8 exec low: every io_sel value ignored
    for (int s = 0; s < 64; s++) begin
      io_exec = 1'b0; io_sel = 6'(s);
      settle();
      eq("R8 no skip", pc_inc, 0);
      eq("R8 no load", acc_lo_load, 0);
      tick();
      settle();
      eq("R8 in flag", in_ready, 0);
      eq("R8 out flag", out_valid, 0);
      eq("R8 ien kept off", irq_cycle, 0);
    end
    idle();

    // R5 ION+IOF together: IOF wins
    exec(6'b000011); tick(); idle(); tick(); settle();
    eq("R5 both -> off", irq_cycle, 0);

    // R6 blocked phases (ien on, flags set)
    exec(6'b000010); sc_phase = 3'b001; tick(); idle();
    for (int p = 0; p < 3; p++) begin
      sc_phase = 3'(1 << p);
      tick(); settle();
      eq("R6 blocked", irq_cycle, 0);
    end
    // R6/R5 open phase sets R
    sc_phase = 3'b000; tick(); settle();
    eq("R6 set", irq_cycle, 1);

    // R7 interrupt cycle
    pc_in = 12'h2A5; sc_phase = 3'b001; settle();
    eq("R7 T0 no write", mem_we, 0);
    tick();
    pc_in = 12'h2A6; sc_phase = 3'b010; settle();
    eq("R7 T1 we", mem_we, 1);
    eq("R7 T1 addr", mem_addr, 0);
    eq("R7 T1 data", mem_wdata, 16'h02A5);
    eq("R7 T1 pc clear", pc_clear, 1);
    tick();
    sc_phase = 3'b100; settle();
    eq("R7 T2 inc", pc_inc, 1);
    eq("R7 T2 sc clear", sc_clear, 1);
    tick();
    sc_phase = 3'b000; settle();
    eq("R7 R dropped", irq_cycle, 0);
    tick(); settle();
    eq("R7 ien off", irq_cycle, 0);

    // R6 no flag, ien on: no set
    in_valid = 1'b0;
    exec(6'b100000); tick(); idle();
    acc_lo_in = 8'h09; exec(6'b010000); tick(); idle();
    exec(6'b000010); sc_phase = 3'b001; tick(); idle();
    sc_phase = 3'b000; tick(); settle();
    eq("R6 no flag", irq_cycle, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule